// File: doc/BRIEF.md
# Packed 4:2:2 to 4:4:4 Chroma Upsampler

This block sits in a streaming video pipeline between a source of packed 4:2:2 luma/chroma data and a consumer that wants full-resolution 4:4:4 pixels. Both sides are AXI4-Stream style channels of 64 bits. Every input beat holds two 4:2:2 groups. Each group is two luma samples that share one U and one V sample.

The block restores full chroma resolution by copying each group's U and V into both pixels of that group. It does not filter. Each output pixel takes 32 bits: V, U and Y, with a zero byte on top that is kept free for a later alpha value. One group therefore fills one output beat, and each input beat yields two output beats.

A four-state handshake machine paces the transfer. It takes one input beat and then presents the two output beats in turn. Each output beat is held until the consumer accepts it. Only after the second beat has been accepted does the machine raise input ready again. The input end-of-packet flag moves to the second output beat made from that input, and after that beat the block goes back to idle.

Top module: `yuv422_expand`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: The cycle after an input handshake, `out_valid` is 1, `in_ready` is 0 and `out_last` is 0. `out_data` then carries the group held in input bits 31:0. Input byte order within a group, from the least significant byte, is Y0, U, Y1, V.
- R3: Each output pixel is formatted as V in bits 7:0, U in bits 15:8, Y in bits 23:16 and zero in bits 31:24. The pixel built from Y0 goes in output bits 31:0 and the pixel built from Y1 goes in bits 63:32. Both pixels carry the group's U and V.
- R4: After the first output beat is accepted, the next cycle presents the second beat, built from input bits 63:32 in the same format.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` keep their values on the next cycle.
- R6: While output beats are pending, `in_ready` is 0, and any change to `in_data`, `in_valid` or `in_last` has no effect on the output beats that are pending.
- R7: After the second output beat is accepted, `out_valid` is 0 and `in_ready` is 1 on the next cycle. A new input beat can then be accepted.
- R8: `out_last` equals the captured input `in_last` on the second output beat, and is 0 on the first output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Two packed 4:2:2 groups |
| in_valid | input | 1 | Input beat valid |
| in_last | input | 1 | Input end of packet |
| in_ready | output | 1 | Block can accept an input beat |
| out_data | output | 64 | Two 32-bit 4:4:4 pixels |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Output end of packet |
| out_ready | input | 1 | Consumer accepts the output beat |

## Verification
The first output beat is due one cycle after the input handshake edge. The second beat is due one cycle after the first is accepted. Input ready comes back one cycle after the second beat is accepted. The bench drives its inputs on the falling edge and samples each result on the falling edge that follows the rising edge at which that result should appear, so every check lands in the single cycle that the requirement names. During stalls of several cycles the bench feeds changing data on the input. It checks at every cycle of the stall that the pending outputs stay unchanged, and checks again after the stall that the second beat still comes from the original input.

// File: rtl/yuv422_expand.sv
module yuv422_expand #(
  parameter int SAMPLE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [8*SAMPLE_W-1:0] in_data,
  input  logic                  in_valid,
  input  logic                  in_last,
  output logic                  in_ready,
  output logic [8*SAMPLE_W-1:0] out_data,
  output logic                  out_valid,
  output logic                  out_last,
  input  logic                  out_ready
);
  localparam int GROUP_W = 4 * SAMPLE_W;
  localparam int BEAT_W  = 2 * GROUP_W;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WR1, ST_WR2} state_t;

  state_t             st;
  logic [BEAT_W-1:0]  hold_q;
  logic               last_q;
  logic [GROUP_W-1:0] grp;
  logic [SAMPLE_W-1:0] y0, y1, cu, cv;

  function automatic logic [GROUP_W-1:0] mk_pix(input logic [SAMPLE_W-1:0] y,
                                                input logic [SAMPLE_W-1:0] u,
                                                input logic [SAMPLE_W-1:0] v);
    return {{SAMPLE_W{1'b0}}, y, u, v};
  endfunction

  assign in_ready  = (st == ST_IDLE) || (st == ST_READ);
  assign out_valid = (st == ST_WR1) || (st == ST_WR2);
  assign out_last  = (st == ST_WR2) && last_q;

  assign grp = (st == ST_WR2) ? hold_q[BEAT_W-1:GROUP_W] : hold_q[GROUP_W-1:0];
  assign y0  = grp[SAMPLE_W-1:0];
  assign cu  = grp[2*SAMPLE_W-1:SAMPLE_W];
  assign y1  = grp[3*SAMPLE_W-1:2*SAMPLE_W];
  assign cv  = grp[4*SAMPLE_W-1:3*SAMPLE_W];

  assign out_data = {mk_pix(y1, cu, cv), mk_pix(y0, cu, cv)};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      hold_q <= '0;
      last_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_READ: if (in_valid) begin
          hold_q <= in_data;
          last_q <= in_last;
          st     <= ST_WR1;
        end
        ST_WR1: if (out_ready) st <= ST_WR2;
        ST_WR2: if (out_ready) st <= last_q ? ST_IDLE : ST_READ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r2_beat_follows_input: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && !in_ready && !out_last);

  a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r4_second_follows_first: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && $past(in_valid && in_ready) |=> out_valid);

  a_r7_ready_after_last_beat: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);

  a_r6_no_input_while_pending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
endmodule

// File: tb/yuv422_expand_tb.sv
module yuv422_expand_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] in_data;
  logic        in_valid, in_last, in_ready;
  logic [63:0] out_data;
  logic        out_valid, out_last, out_ready;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  yuv422_expand u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready)
  );

  function automatic logic [63:0] expect_beat(input logic [31:0] g);
    logic [7:0] y0, u, y1, v;
    y0 = g[7:0]; u = g[15:8]; y1 = g[23:16]; v = g[31:24];
    return {8'h00, y1, u, v, 8'h00, y0, u, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_beat(input logic [63:0] d, input logic lst, input int stall1, input int stall2);
    @(negedge clk);
    in_data = d; in_valid = 1'b1; in_last = lst; out_ready = 1'b0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_data = ~d;
    chk("R2 valid/ready/last after input", {61'd0, out_valid, in_ready, out_last}, 64'b100);
    chk("R2 R3 first beat data", out_data, expect_beat(d[31:0]));
    for (int i = 0; i < stall1; i++) begin
      in_valid = 1'b1; in_data = d ^ {32'(i * 7 + 3), 32'(i + 1)}; in_last = ~lst;
      @(negedge clk);
      chk("R5 R6 first beat held", {out_data, 3'b0} | {64'd0}, {expect_beat(d[31:0]), 3'b0});
      chk("R5 R6 valid held, ready low", {62'd0, out_valid, in_ready}, 64'b10);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R4 second beat data", out_data, expect_beat(d[63:32]));
    chk("R8 last on second beat", {62'd0, out_valid, out_last}, {62'd0, 1'b1, lst});
    for (int i = 0; i < stall2; i++) begin
      in_valid = 1'b1; in_data = {d[31:0], d[63:32]};
      @(negedge clk);
      chk("R5 second beat held", out_data, expect_beat(d[63:32]));
      chk("R5 R8 last held", {62'd0, out_valid, out_last}, {62'd0, 1'b1, lst});
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 idle after second beat", {62'd0, out_valid, in_ready}, 64'b01);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", {61'd0, out_valid, out_last, in_ready}, 64'b001);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {61'd0, out_valid, out_last, in_ready}, 64'b001);
  endtask

  task automatic t_single;
    send_beat(64'h8877_6655_4433_2211, 1'b1, 0, 0);
  endtask

  task automatic t_burst;
    send_beat(64'h0123_4567_89AB_CDEF, 1'b0, 0, 0);
    send_beat(64'hFEDC_BA98_7654_3210, 1'b0, 0, 0);
    send_beat(64'h1357_9BDF_2468_ACE0, 1'b1, 0, 0);
  endtask

  task automatic t_backpressure;
    send_beat(64'hA5A5_5A5A_C3C3_3C3C, 1'b0, 3, 2);
    send_beat(64'h0F1E_2D3C_4B5A_6978, 1'b1, 1, 4);
  endtask

  task automatic t_extremes;
    send_beat(64'hFFFF_FFFF_0000_0000, 1'b0, 0, 1);
    send_beat(64'h00FF_00FF_FF00_FF00, 1'b1, 2, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_burst();
    t_backpressure();
    t_extremes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule